// File: doc/BRIEF.md
# Memory-Cycle Trap State Keeper

This block holds the deferred trap state left behind by memory cycles. When a memory read or write starts, both trap flags are cleared and a lookup is opened. When the map, transport and GC logic later report their result for that cycle, the block records any fault. A read fault is parked in a read-trap flag and stays silent until the processor actually consumes the memory data register (MD). Each accepted consumption of MD while the flag is set raises a one-cycle read trap request in the following cycle. A write fault sets the write-trap flag, and that flag is itself the trap.

Both flags can be read and written directly through a small software port. A trap handler can therefore save them, do unrelated memory work, and restore them so that the interrupted code traps again when it next reads MD. The block also drives a freeze output. It stalls an MD consumer while MD is not yet valid, or while the read lookup that decides the read-trap flag is still open.

A small sequencer tracks which lookup is open. Its states are LK_IDLE (no lookup open), LK_RD_WAIT (read lookup open) and LK_WR_WAIT (write lookup open). It has these transitions:
- **start-read**: from any state to LK_RD_WAIT.
- **start-write**: from any state to LK_WR_WAIT.
- **resolve**: from LK_RD_WAIT or LK_WR_WAIT to LK_IDLE when the lookup result arrives and no new cycle starts.
- **hold**: otherwise the state does not change.

Top module: `memtrap_state`

## Requirements
- R1: After reset, rd_trap, wr_trap, rd_treq and freeze are 0 and no lookup is open.
- R2: A clock edge with rd_start or wr_start high clears rd_trap and wr_trap, unless software writes that flag in the same cycle.
- R3: While a read lookup is open, a clock edge with chk_vld high sets rd_trap to 1 if any bit of chk_fault is 1, and to 0 otherwise. This closes the lookup.
- R4: While a write lookup is open, a clock edge with chk_vld high and any chk_fault bit set makes wr_trap 1. wr_trap then holds until software clears it or a new cycle starts.
- R5: A cycle with md_src high, freeze low and rd_trap high makes rd_treq 1 in the next cycle only. Consuming MD never changes rd_trap, so every later such consumption traps again.
- R6: rd_treq is 0 in every cycle that does not follow an accepted MD consumption with rd_trap set.
- R7: freeze is 1 exactly when md_src is high and either md_valid is low or a read lookup is open. A frozen consumption raises no rd_treq.
- R8: A clock edge with sw_rd_we (sw_wr_we) high loads rd_trap (wr_trap) from sw_rd_val (sw_wr_val). This write overrides any hardware update in that cycle.
- R9: rd_start takes precedence over a simultaneous wr_start and opens a read lookup. A chk_vld in the same cycle as any start is ignored, and the new lookup stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_start | input | 1 | A memory read (normal or early) starts this cycle |
| wr_start | input | 1 | A memory write starts this cycle |
| chk_vld | input | 1 | Map/GC lookup result for the open cycle is present |
| chk_fault | input | FAULT_W | Fault indications (page fault, transport, GC, ...) |
| md_src | input | 1 | The instruction in flight sources MD this cycle |
| md_valid | input | 1 | MD contents are valid |
| sw_rd_we | input | 1 | Software write strobe for rd_trap |
| sw_rd_val | input | 1 | Value written to rd_trap |
| sw_wr_we | input | 1 | Software write strobe for wr_trap |
| sw_wr_val | input | 1 | Value written to wr_trap |
| rd_trap | output | 1 | Read-trap flag |
| wr_trap | output | 1 | Write-trap flag (also the write trap) |
| rd_treq | output | 1 | Read trap request, read-only status |
| freeze | output | 1 | Stall request for the MD consumer |

## Verification
The bench builds the block with FAULT_W = 3 instead of the default 2. This shows that a fault on the upper source bit sets a flag just as the lower bits do. Directed sequences cover save/restore through the software port, repeated MD consumption while rd_trap is set, and freeze during an open read lookup. They also cover a start colliding with a lookup result and with a software write. A long stretch of random stimulus then drives every input at once, so that start, lookup, consumption and software write collide in all combinations.

// File: rtl/memtrap_pkg.sv
package memtrap_pkg;
    typedef enum logic [1:0] {
        LK_IDLE    = 2'd0,
        LK_RD_WAIT = 2'd1,
        LK_WR_WAIT = 2'd2
    } lk_state_t;
endpackage

// File: rtl/mtrap_seq.sv
module mtrap_seq
    import memtrap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_start,
    input  logic wr_start,
    input  logic chk_vld,
    output logic rd_wait,
    output logic rd_resolve,
    output logic wr_resolve
);
    lk_state_t state_q, state_d;
    logic      any_start;

    assign any_start = rd_start | wr_start;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    // next-state: starts win over resolve
    always_comb begin
        state_d = state_q;
        if (rd_start)      state_d = LK_RD_WAIT;
        else if (wr_start) state_d = LK_WR_WAIT;
        else begin
            unique case (state_q)
                LK_IDLE:    state_d = LK_IDLE;
                LK_RD_WAIT: if (chk_vld) state_d = LK_IDLE;
                LK_WR_WAIT: if (chk_vld) state_d = LK_IDLE;
                default:    state_d = LK_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_wait    = 1'b0;
        rd_resolve = 1'b0;
        wr_resolve = 1'b0;
        unique case (state_q)
            LK_IDLE: ;
            LK_RD_WAIT: begin
                rd_wait    = 1'b1;
                rd_resolve = chk_vld & ~any_start;
            end
            LK_WR_WAIT: wr_resolve = chk_vld & ~any_start;
            default: ;
        endcase
    end
endmodule

// File: rtl/mtrap_flags.sv
module mtrap_flags #(
    parameter int FAULT_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               any_start,
    input  logic               rd_resolve,
    input  logic               wr_resolve,
    input  logic [FAULT_W-1:0] chk_fault,
    input  logic               sw_rd_we,
    input  logic               sw_rd_val,
    input  logic               sw_wr_we,
    input  logic               sw_wr_val,
    output logic               rd_trap,
    output logic               wr_trap
);
    logic faulted;
    logic rd_d, wr_d;

    assign faulted = |chk_fault;

    always_comb begin
        rd_d = rd_trap;
        if (sw_rd_we)        rd_d = sw_rd_val;
        else if (any_start)  rd_d = 1'b0;
        else if (rd_resolve) rd_d = faulted;
    end

    always_comb begin
        wr_d = wr_trap;
        if (sw_wr_we)        wr_d = sw_wr_val;
        else if (any_start)  wr_d = 1'b0;
        else if (wr_resolve && faulted) wr_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_trap <= 1'b0;
            wr_trap <= 1'b0;
        end else begin
            rd_trap <= rd_d;
            wr_trap <= wr_d;
        end
    end
endmodule

// File: rtl/mtrap_req.sv
module mtrap_req (
    input  logic clk,
    input  logic rst_n,
    input  logic md_src,
    input  logic md_valid,
    input  logic rd_wait,
    input  logic rd_trap,
    output logic freeze,
    output logic rd_treq
);
    logic accepted;

    assign freeze   = md_src & (~md_valid | rd_wait);
    assign accepted = md_src & ~freeze;

    always_ff @(posedge clk) begin
        if (!rst_n) rd_treq <= 1'b0;
        else        rd_treq <= accepted & rd_trap;
    end
endmodule

// File: rtl/memtrap_state.sv
module memtrap_state #(
    parameter int FAULT_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_start,
    input  logic               wr_start,
    input  logic               chk_vld,
    input  logic [FAULT_W-1:0] chk_fault,
    input  logic               md_src,
    input  logic               md_valid,
    input  logic               sw_rd_we,
    input  logic               sw_rd_val,
    input  logic               sw_wr_we,
    input  logic               sw_wr_val,
    output logic               rd_trap,
    output logic               wr_trap,
    output logic               rd_treq,
    output logic               freeze
);
    logic rd_wait, rd_resolve, wr_resolve;

    mtrap_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_start   (rd_start),
        .wr_start   (wr_start),
        .chk_vld    (chk_vld),
        .rd_wait    (rd_wait),
        .rd_resolve (rd_resolve),
        .wr_resolve (wr_resolve)
    );

    mtrap_flags #(.FAULT_W(FAULT_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_start  (rd_start | wr_start),
        .rd_resolve (rd_resolve),
        .wr_resolve (wr_resolve),
        .chk_fault  (chk_fault),
        .sw_rd_we   (sw_rd_we),
        .sw_rd_val  (sw_rd_val),
        .sw_wr_we   (sw_wr_we),
        .sw_wr_val  (sw_wr_val),
        .rd_trap    (rd_trap),
        .wr_trap    (wr_trap)
    );

    mtrap_req u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .md_src   (md_src),
        .md_valid (md_valid),
        .rd_wait  (rd_wait),
        .rd_trap  (rd_trap),
        .freeze   (freeze),
        .rd_treq  (rd_treq)
    );
endmodule

// File: rtl/memtrap_state_chk.sv
module memtrap_state_chk #(
    parameter int FAULT_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_start,
    input logic               wr_start,
    input logic               chk_vld,
    input logic [FAULT_W-1:0] chk_fault,
    input logic               md_src,
    input logic               md_valid,
    input logic               sw_rd_we,
    input logic               sw_rd_val,
    input logic               sw_wr_we,
    input logic               sw_wr_val,
    input logic               rd_trap,
    input logic               wr_trap,
    input logic               rd_treq,
    input logic               freeze
);
    a_r2_start_clears_rd: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_start || wr_start) && !sw_rd_we) |=> !rd_trap);

    a_r2_start_clears_wr: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_start || wr_start) && !sw_wr_we) |=> !wr_trap);

    a_r5_accepted_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (md_src && !freeze && rd_trap) |=> rd_treq);

    a_r6_no_spurious_treq: assert property (@(posedge clk) disable iff (!rst_n)
        !(md_src && !freeze && rd_trap) |=> !rd_treq);

    a_r7_freeze_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> md_src);

    a_r7_invalid_md_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (md_src && !md_valid) |-> freeze);

    a_r8_sw_rd_write: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rd_we |=> (rd_trap == $past(sw_rd_val)));

    a_r8_sw_wr_write: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_we |=> (wr_trap == $past(sw_wr_val)));

    a_r4_wr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_trap && !sw_wr_we && !rd_start && !wr_start) |=> wr_trap);

    a_r5_src_keeps_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_rd_we && !rd_start && !wr_start && !chk_vld) |=> $stable(rd_trap));
endmodule

bind memtrap_state memtrap_state_chk #(.FAULT_W(FAULT_W)) u_chk (.*);

// File: tb/memtrap_state_test.sv
module memtrap_state_test;
    localparam int FW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_start = 0, wr_start = 0, chk_vld = 0, md_src = 0, md_valid = 1;
    logic [FW-1:0] chk_fault = '0;
    logic sw_rd_we = 0, sw_rd_val = 0, sw_wr_we = 0, sw_wr_val = 0;
    logic rd_trap, wr_trap, rd_treq, freeze;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // reference model state: pend 0 none, 1 read lookup, 2 write lookup
    int m_pend = 0;
    bit m_rd = 0, m_wr = 0, m_treq = 0;

    always #10 clk = ~clk;

    memtrap_state #(.FAULT_W(FW)) uut (.*);

    task automatic cmp(input string what, input bit act, input bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic clear_in();
        rd_start = 0; wr_start = 0; chk_vld = 0; chk_fault = '0;
        md_src = 0; md_valid = 1; sw_rd_we = 0; sw_rd_val = 0;
        sw_wr_we = 0; sw_wr_val = 0;
    endtask

    // inputs already set; check freeze, advance model and one clock, check regs
    task automatic cyc();
        bit fz, acc, flt, starting;
        #2;
        fz = md_src && (!md_valid || m_pend == 1);
        cmp("freeze", freeze, fz);
        acc = md_src && !fz;
        flt = (chk_fault != 0);
        starting = rd_start || wr_start;
        m_treq = acc && m_rd;
        if (sw_rd_we) m_rd = sw_rd_val;
        else if (starting) m_rd = 0;
        else if (m_pend == 1 && chk_vld) m_rd = flt;
        if (sw_wr_we) m_wr = sw_wr_val;
        else if (starting) m_wr = 0;
        else if (m_pend == 2 && chk_vld && flt) m_wr = 1;
        if (rd_start) m_pend = 1;
        else if (wr_start) m_pend = 2;
        else if (chk_vld) m_pend = 0;
        @(posedge clk);
        #2;
        cmp("rd_trap", rd_trap, m_rd);
        cmp("wr_trap", wr_trap, m_wr);
        cmp("rd_treq", rd_treq, m_treq);
        clear_in();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin : watchdog
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        clear_in();
        repeat (3) @(posedge clk);
        #2;
        cur_req = "R1";
        cmp("rd_trap", rd_trap, 0); cmp("wr_trap", wr_trap, 0);
        cmp("rd_treq", rd_treq, 0); cmp("freeze", freeze, 0);
        @(negedge clk);
        rst_n = 1;
        idle(2);

        // R3: read fault on upper bit, then resolve
        cur_req = "R3";
        rd_start = 1; cyc();
        idle(1);
        chk_vld = 1; chk_fault = 3'b100; cyc();
        // R6: no MD source, no trap
        cur_req = "R6"; idle(3);
        // R5: repeated accepted sources trap each time
        cur_req = "R5";
        md_src = 1; cyc();
        md_src = 1; cyc();
        idle(1);
        md_src = 1; cyc();
        // R7: invalid MD freezes, no trap
        cur_req = "R7";
        md_src = 1; md_valid = 0; cyc();
        md_src = 1; md_valid = 0; cyc();
        // R2: new write start clears rd_trap
        cur_req = "R2";
        wr_start = 1; cyc();
        // R4: write fault sets wr_trap, holds
        cur_req = "R4";
        chk_vld = 1; chk_fault = 3'b001; cyc();
        idle(3);
        // R8: save/restore through the software port
        cur_req = "R8";
        sw_wr_we = 1; sw_wr_val = 0; cyc();
        sw_rd_we = 1; sw_rd_val = 1; rd_start = 1; cyc();
        // R7: source during open read lookup freezes
        cur_req = "R7";
        md_src = 1; cyc();
        chk_vld = 1; chk_fault = 3'b000; cyc();
        cur_req = "R3";
        md_src = 1; cyc();
        // R9: simultaneous starts open a read; chk_vld with start ignored
        cur_req = "R9";
        rd_start = 1; wr_start = 1; cyc();
        rd_start = 1; chk_vld = 1; chk_fault = 3'b010; cyc();
        md_src = 1; cyc();
        chk_vld = 1; chk_fault = 3'b010; cyc();
        md_src = 1; cyc();
        // R8: software write beats hardware resolve
        cur_req = "R8";
        wr_start = 1; cyc();
        chk_vld = 1; chk_fault = 3'b111; sw_wr_we = 1; sw_wr_val = 0; cyc();
        idle(2);

        // random mix covering R2 through R9
        cur_req = "R2-R9 random";
        for (int i = 0; i < 3000; i++) begin
            rd_start  = ($urandom_range(0, 7) == 0);
            wr_start  = ($urandom_range(0, 7) == 0);
            chk_vld   = ($urandom_range(0, 2) == 0);
            chk_fault = FW'($urandom_range(0, 7));
            md_src    = ($urandom_range(0, 1) == 0);
            md_valid  = ($urandom_range(0, 3) != 0);
            sw_rd_we  = ($urandom_range(0, 9) == 0);
            sw_rd_val = $urandom_range(0, 1) == 1;
            sw_wr_we  = ($urandom_range(0, 9) == 0);
            sw_wr_val = $urandom_range(0, 1) == 1;
            cyc();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule